// File: doc/BRIEF.md
# Reuse-Aware Register Rename Unit

This unit renames one instruction per cycle for an out-of-order core. It translates the logical source and destination registers into physical tags through a map table. A free list hands out physical registers. Each physical register also carries two pieces of metadata: an "already read" flag and a small version counter. The unit's distinguishing move is to skip the free list when a value is consumed exactly once. If the instruction is the first to read a source's physical register, and is also judged to be its final reader, that same physical register becomes the instruction's destination. The register's version is bumped so that the two lifetimes stay distinguishable.

The final-reader judgement comes from two places. It is certain when the destination logical register equals the source logical register. Otherwise it follows a per-source last-use hint supplied by an external predictor. Renamed tags and versions leave the unit one cycle after the instruction is accepted. The unit raises a combinational stall when it cannot accept an instruction. Committed registers are returned through a release port and appended to the free list.

Top module: `rn_reuse_rename`

## Requirements
- R1: After reset the map table maps logical register i to physical register i. The free list holds physical registers NUM_LOG..NUM_PHYS-1 and pops them in ascending order. `out_valid` and `stall` are 0, every read flag is set, and every version counter is 0.
- R2: An enabled source whose physical register has its read flag clear makes the instruction that register's first reader. Acceptance sets the flag, so a later instruction naming that register cannot reuse it.
- R3: A first reader that has a destination equal to the source's logical register reuses that source's physical register, whatever the last-use hint says.
- R4: A first reader with a different destination logical register reuses the source's physical register only when that source's last-use hint is 1.
- R5: On reuse, `out_dst_tag` equals the reused source's physical tag, `out_reused` is 1, and no free-list entry is consumed.
- R6: Without reuse, a destination takes the free-list head. Free-list order is first in, first out, and released tags join at the tail.
- R7: A destination assignment reports the register's current counter value as `out_dst_ver`. The counter then increments modulo 4, wrapping from 3 to 0. This applies to both reuse and free-list allocation.
- R8: Each renamed source reports in its version output the version of its register's latest write, which is the counter value minus one modulo 4 at rename time.
- R9: When both sources qualify for reuse, source 0 is reused and only one register is reused.
- R10: When a valid instruction has a destination, no reuse applies and the free list is empty, `stall` is 1. The instruction is not accepted and no map, flag, version or free-list state changes.
- R11: An instruction without a destination sets the read flags of its sources. It never allocates or reuses a register, never changes a version, and reports `out_dst_valid` = 0.
- R12: Assigning a register as a destination clears its read flag. This wins over a source read of the same register in the same cycle, so a reused register can be reused again by its next single consumer.
- R13: A release and a free-list allocation in the same cycle both take effect. A release arriving during a stall is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present for renaming |
| in_src0_en | input | 1 | Source 0 is used |
| in_src0 | input | LOG_W | Source 0 logical register |
| in_src0_last | input | 1 | Last-use hint for source 0 |
| in_src1_en | input | 1 | Source 1 is used |
| in_src1 | input | LOG_W | Source 1 logical register |
| in_src1_last | input | 1 | Last-use hint for source 1 |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_dst | input | LOG_W | Destination logical register |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_tag | input | PHYS_W | Tag being returned |
| stall | output | 1 | Instruction cannot be accepted this cycle |
| out_valid | output | 1 | Renamed result valid |
| out_src0_tag | output | PHYS_W | Physical tag of source 0 |
| out_src0_ver | output | VER_W | Version of source 0 |
| out_src1_tag | output | PHYS_W | Physical tag of source 1 |
| out_src1_ver | output | VER_W | Version of source 1 |
| out_dst_valid | output | 1 | A destination was assigned |
| out_dst_tag | output | PHYS_W | Physical tag of the destination |
| out_dst_ver | output | VER_W | Write version of the destination |
| out_reused | output | 1 | Destination reused a source register |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a destination assignment and a source read of the same physical register. A same-register reuse provokes it: the flag clear must win, which the bench judges by letting the next single consumer reuse the register again. The second pair is a free-list pop and a release push. The bench drains the list, then releases during a stall, and then releases while allocating. It judges the outcome by which tags the following allocations receive.

// File: rtl/rn_pkg.sv
package rn_pkg;

   typedef enum logic [1:0] {
      RN_PICK_NONE = 2'd0,
      RN_PICK_SRC0 = 2'd1,
      RN_PICK_SRC1 = 2'd2
   } rn_pick_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int NUM_LOG  = 16,
   parameter int NUM_PHYS = 32,
   localparam int LOG_W   = $clog2(NUM_LOG),
   localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOG_W-1:0]  rd0_idx,
   input  logic [LOG_W-1:0]  rd1_idx,
   output logic [PHYS_W-1:0] rd0_tag,
   output logic [PHYS_W-1:0] rd1_tag,
   input  logic              wr_en,
   input  logic [LOG_W-1:0]  wr_idx,
   input  logic [PHYS_W-1:0] wr_tag
);

   logic [PHYS_W-1:0] map_q [NUM_LOG];

   if (NUM_PHYS < NUM_LOG) begin : g_bad_size
      $error("rn_map_table: NUM_PHYS must be at least NUM_LOG");
   end

   for (genvar i = 0; i < NUM_LOG; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            map_q[i] <= PHYS_W'(i);
         end else if (wr_en && (wr_idx == LOG_W'(i))) begin
            map_q[i] <= wr_tag;
         end
      end
   end

   assign rd0_tag = map_q[rd0_idx];
   assign rd1_tag = map_q[rd1_idx];

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
   parameter int NUM_LOG  = 16,
   parameter int NUM_PHYS = 32,
   localparam int PHYS_W  = $clog2(NUM_PHYS),
   localparam int CNT_W   = PHYS_W + 1,
   localparam int INIT    = NUM_PHYS - NUM_LOG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop,
   input  logic              push,
   input  logic [PHYS_W-1:0] push_tag,
   output logic [PHYS_W-1:0] head_tag,
   output logic              empty,
   output logic              full
);

   logic [PHYS_W-1:0] slot_q [NUM_PHYS];
   logic [PHYS_W-1:0] rd_ptr_q;
   logic [PHYS_W-1:0] wr_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_d;

   if ((1 << PHYS_W) != NUM_PHYS) begin : g_bad_depth
      $error("rn_free_list: NUM_PHYS must be a power of two");
   end

   for (genvar k = 0; k < NUM_PHYS; k++) begin : g_slot
      localparam int RST_VAL = (k < INIT) ? (NUM_LOG + k) : 0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[k] <= PHYS_W'(RST_VAL);
         end else if (push && (wr_ptr_q == PHYS_W'(k))) begin
            slot_q[k] <= push_tag;
         end
      end
   end

   always_comb begin
      cnt_d = cnt_q;
      if (push && !pop) cnt_d = cnt_q + CNT_W'(1);
      if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= PHYS_W'(INIT);
         cnt_q    <= CNT_W'(INIT);
      end else begin
         if (pop)  rd_ptr_q <= rd_ptr_q + PHYS_W'(1);
         if (push) wr_ptr_q <= wr_ptr_q + PHYS_W'(1);
         cnt_q <= cnt_d;
      end
   end

   assign head_tag = slot_q[rd_ptr_q];
   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CNT_W'(NUM_PHYS));

   AST_FL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);  // R10
   AST_FL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));  // R13
   AST_FL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(cnt_q));  // R5

endmodule

// File: rtl/rn_phys_meta.sv
module rn_phys_meta #(
   parameter int NUM_PHYS = 32,
   parameter int VER_W    = 2,
   localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHYS_W-1:0] q0_tag,
   input  logic [PHYS_W-1:0] q1_tag,
   input  logic [PHYS_W-1:0] qd_tag,
   output logic              q0_read,
   output logic              q1_read,
   output logic [VER_W-1:0]  q0_ver,
   output logic [VER_W-1:0]  q1_ver,
   output logic [VER_W-1:0]  qd_ver,
   input  logic              set0_en,
   input  logic              set1_en,
   input  logic              asg_en,
   input  logic [PHYS_W-1:0] asg_tag
);

   logic             read_q [NUM_PHYS];
   logic [VER_W-1:0] ver_q  [NUM_PHYS];

   if (VER_W < 1) begin : g_bad_ver
      $error("rn_phys_meta: VER_W must be at least 1");
   end

   for (genvar i = 0; i < NUM_PHYS; i++) begin : g_reg
      logic hit_s0, hit_s1, hit_asg;
      assign hit_s0  = set0_en && (q0_tag == PHYS_W'(i));
      assign hit_s1  = set1_en && (q1_tag == PHYS_W'(i));
      assign hit_asg = asg_en  && (asg_tag == PHYS_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            read_q[i] <= 1'b1;
            ver_q[i]  <= '0;
         end else begin
            if (hit_asg) begin
               read_q[i] <= 1'b0;
               ver_q[i]  <= ver_q[i] + VER_W'(1);
            end else if (hit_s0 || hit_s1) begin
               read_q[i] <= 1'b1;
            end
         end
      end
   end

   assign q0_read = read_q[q0_tag];
   assign q1_read = read_q[q1_tag];
   assign q0_ver  = ver_q[q0_tag];
   assign q1_ver  = ver_q[q1_tag];
   assign qd_ver  = ver_q[qd_tag];

   AST_ASG_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      asg_en |=> !read_q[$past(asg_tag)]);  // R12
   AST_ASG_BUMPS_VER: assert property (@(posedge clk) disable iff (!rst_n)
      asg_en |=> (ver_q[$past(asg_tag)] == $past(qd_ver) + VER_W'(1)));  // R7

endmodule

// File: rtl/rn_reuse_pick.sv
module rn_reuse_pick
   import rn_pkg::*;
#(
   parameter int LOG_W  = 4,
   parameter int PHYS_W = 5
) (
   input  logic              has_dst,
   input  logic [LOG_W-1:0]  dst,
   input  logic              s0_en,
   input  logic [LOG_W-1:0]  s0,
   input  logic              s0_last,
   input  logic              s0_read,
   input  logic [PHYS_W-1:0] s0_tag,
   input  logic              s1_en,
   input  logic [LOG_W-1:0]  s1,
   input  logic              s1_last,
   input  logic              s1_read,
   input  logic [PHYS_W-1:0] s1_tag,
   output rn_pick_e          pick,
   output logic              reuse,
   output logic [PHYS_W-1:0] reuse_tag
);

   logic first0, first1, ok0, ok1;

   assign first0 = s0_en && !s0_read;
   assign first1 = s1_en && !s1_read;
   assign ok0    = has_dst && first0 && ((dst == s0) || s0_last);
   assign ok1    = has_dst && first1 && ((dst == s1) || s1_last);

   always_comb begin
      pick      = RN_PICK_NONE;
      reuse_tag = s0_tag;
      if (ok0) begin
         pick      = RN_PICK_SRC0;
         reuse_tag = s0_tag;
      end else if (ok1) begin
         pick      = RN_PICK_SRC1;
         reuse_tag = s1_tag;
      end
   end

   assign reuse = (pick != RN_PICK_NONE);

endmodule

// File: rtl/rn_reuse_rename.sv
module rn_reuse_rename
   import rn_pkg::*;
#(
   parameter int NUM_LOG  = 16,
   parameter int NUM_PHYS = 32,
   parameter int VER_W    = 2,
   localparam int LOG_W   = $clog2(NUM_LOG),
   localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_src0_en,
   input  logic [LOG_W-1:0]  in_src0,
   input  logic              in_src0_last,
   input  logic              in_src1_en,
   input  logic [LOG_W-1:0]  in_src1,
   input  logic              in_src1_last,
   input  logic              in_has_dst,
   input  logic [LOG_W-1:0]  in_dst,
   input  logic              rel_valid,
   input  logic [PHYS_W-1:0] rel_tag,
   output logic              stall,
   output logic              out_valid,
   output logic [PHYS_W-1:0] out_src0_tag,
   output logic [VER_W-1:0]  out_src0_ver,
   output logic [PHYS_W-1:0] out_src1_tag,
   output logic [VER_W-1:0]  out_src1_ver,
   output logic              out_dst_valid,
   output logic [PHYS_W-1:0] out_dst_tag,
   output logic [VER_W-1:0]  out_dst_ver,
   output logic              out_reused
);

   if ((1 << LOG_W) != NUM_LOG) begin : g_bad_log
      $error("rn_reuse_rename: NUM_LOG must be a power of two");
   end
   if (NUM_PHYS <= NUM_LOG) begin : g_bad_phys
      $error("rn_reuse_rename: NUM_PHYS must exceed NUM_LOG");
   end

   logic [PHYS_W-1:0] map0_tag, map1_tag;
   logic              rd0_flag, rd1_flag;
   logic [VER_W-1:0]  cur0_ver, cur1_ver, dst_cur_ver;
   logic [PHYS_W-1:0] fl_head;
   logic              fl_empty, fl_full;
   rn_pick_e          pick;
   logic              reuse;
   logic [PHYS_W-1:0] reuse_tag;
   logic [PHYS_W-1:0] dst_tag;
   logic              fire, asg, fl_pop;
   rn_pick_e          pick_q;

   rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd0_idx (in_src0),
      .rd1_idx (in_src1),
      .rd0_tag (map0_tag),
      .rd1_tag (map1_tag),
      .wr_en   (asg),
      .wr_idx  (in_dst),
      .wr_tag  (dst_tag)
   );

   rn_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) i_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (fl_pop),
      .push     (rel_valid),
      .push_tag (rel_tag),
      .head_tag (fl_head),
      .empty    (fl_empty),
      .full     (fl_full)
   );

   rn_phys_meta #(.NUM_PHYS(NUM_PHYS), .VER_W(VER_W)) i_meta (
      .clk     (clk),
      .rst_n   (rst_n),
      .q0_tag  (map0_tag),
      .q1_tag  (map1_tag),
      .qd_tag  (dst_tag),
      .q0_read (rd0_flag),
      .q1_read (rd1_flag),
      .q0_ver  (cur0_ver),
      .q1_ver  (cur1_ver),
      .qd_ver  (dst_cur_ver),
      .set0_en (fire && in_src0_en),
      .set1_en (fire && in_src1_en),
      .asg_en  (asg),
      .asg_tag (dst_tag)
   );

   rn_reuse_pick #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) i_pick (
      .has_dst   (in_has_dst),
      .dst       (in_dst),
      .s0_en     (in_src0_en),
      .s0        (in_src0),
      .s0_last   (in_src0_last),
      .s0_read   (rd0_flag),
      .s0_tag    (map0_tag),
      .s1_en     (in_src1_en),
      .s1        (in_src1),
      .s1_last   (in_src1_last),
      .s1_read   (rd1_flag),
      .s1_tag    (map1_tag),
      .pick      (pick),
      .reuse     (reuse),
      .reuse_tag (reuse_tag)
   );

   assign stall   = in_valid && in_has_dst && !reuse && fl_empty;
   assign fire    = in_valid && !stall;
   assign asg     = fire && in_has_dst;
   assign fl_pop  = asg && !reuse;
   assign dst_tag = reuse ? reuse_tag : fl_head;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_src0_tag  <= '0;
         out_src0_ver  <= '0;
         out_src1_tag  <= '0;
         out_src1_ver  <= '0;
         out_dst_valid <= 1'b0;
         out_dst_tag   <= '0;
         out_dst_ver   <= '0;
         out_reused    <= 1'b0;
         pick_q        <= RN_PICK_NONE;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_src0_tag  <= map0_tag;
            out_src0_ver  <= cur0_ver - VER_W'(1);
            out_src1_tag  <= map1_tag;
            out_src1_ver  <= cur1_ver - VER_W'(1);
            out_dst_valid <= in_has_dst;
            out_dst_tag   <= dst_tag;
            out_dst_ver   <= dst_cur_ver;
            out_reused    <= asg && reuse;
            pick_q        <= asg ? pick : RN_PICK_NONE;
         end
      end
   end

   AST_STALL_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> fl_empty);  // R10
   AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !out_valid);  // R10
   AST_REUSE_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pick_q == RN_PICK_SRC0) |-> (out_reused && out_dst_tag == out_src0_tag));  // R5
   AST_REUSE_VER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pick_q == RN_PICK_SRC1) |-> (out_dst_ver == out_src1_ver + VER_W'(1)));  // R7
   AST_NODST_NO_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_dst_valid) |-> !out_reused);  // R11
   AST_REL_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> !fl_full);  // R13

endmodule

// File: tb/test_rn_reuse_rename.sv
module test_rn_reuse_rename;

   localparam int NL = 16;
   localparam int NP = 32;
   localparam int LW = 4;
   localparam int PW = 5;
   localparam int VW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_src0_en = 1'b0, in_src0_last = 1'b0;
   logic in_src1_en = 1'b0, in_src1_last = 1'b0;
   logic [LW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
   logic in_has_dst = 1'b0;
   logic rel_valid = 1'b0;
   logic [PW-1:0] rel_tag = '0;
   logic stall, out_valid, out_dst_valid, out_reused;
   logic [PW-1:0] out_src0_tag, out_src1_tag, out_dst_tag;
   logic [VW-1:0] out_src0_ver, out_src1_ver, out_dst_ver;

   always #2.5 clk = ~clk;

   rn_reuse_rename #(.NUM_LOG(NL), .NUM_PHYS(NP), .VER_W(VW)) i_rn_reuse_rename (
      .clk, .rst_n, .in_valid, .in_src0_en, .in_src0, .in_src0_last,
      .in_src1_en, .in_src1, .in_src1_last, .in_has_dst, .in_dst,
      .rel_valid, .rel_tag, .stall, .out_valid, .out_src0_tag, .out_src0_ver,
      .out_src1_tag, .out_src1_ver, .out_dst_valid, .out_dst_tag, .out_dst_ver,
      .out_reused
   );

   typedef struct {
      string         lbl;
      logic          s0e, s1e, hd, ru;
      logic [PW-1:0] s0t, s1t, dt;
      logic [VW-1:0] s0v, s1v, dv;
   } exp_t;

   exp_t          sb[$];
   int            n_run = 0;
   int            n_fail = 0;
   logic [PW-1:0] m_map [NL];
   logic          m_rd  [NP];
   logic [VW-1:0] m_ver [NP];
   logic [PW-1:0] m_fl[$];

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected results as the design produces them
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            chk("R10", "unexpected out_valid", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.s0e) begin
               chk(e.lbl, "src0_tag", out_src0_tag, e.s0t);
               chk("R8", "src0_ver", out_src0_ver, e.s0v);
            end
            if (e.s1e) begin
               chk(e.lbl, "src1_tag", out_src1_tag, e.s1t);
               chk("R8", "src1_ver", out_src1_ver, e.s1v);
            end
            chk("R11", "dst_valid", out_dst_valid, e.hd);
            chk(e.lbl, "reused", out_reused, e.ru);
            if (e.hd) begin
               chk(e.ru ? "R5" : "R6", "dst_tag", out_dst_tag, e.dt);
               chk("R7", "dst_ver", out_dst_ver, e.dv);
            end
         end
      end
   end

   // driver: computes expectations from the requirements, then drives one cycle
   task automatic issue(string lbl, bit v, bit hd, int d, bit e0, int s0, bit l0,
                        bit e1, int s1, bit l1, bit rv, int rt);
      exp_t e;
      logic [PW-1:0] p0, p1;
      bit q0, q1, ru, st;
      p0 = m_map[s0];
      p1 = m_map[s1];
      q0 = hd && e0 && !m_rd[p0] && ((d == s0) || l0);
      q1 = hd && e1 && !m_rd[p1] && ((d == s1) || l1);
      ru = q0 || q1;
      st = v && hd && !ru && (m_fl.size() == 0);
      in_valid = v; in_has_dst = hd; in_dst = LW'(d);
      in_src0_en = e0; in_src0 = LW'(s0); in_src0_last = l0;
      in_src1_en = e1; in_src1 = LW'(s1); in_src1_last = l1;
      rel_valid = rv; rel_tag = PW'(rt);
      if (v && !st) begin
         e.lbl = lbl; e.s0e = e0; e.s1e = e1; e.hd = hd; e.ru = ru;
         e.s0t = p0; e.s1t = p1;
         e.s0v = m_ver[p0] - 2'd1; e.s1v = m_ver[p1] - 2'd1;
         e.dt = '0; e.dv = '0;
         if (e0) m_rd[p0] = 1'b1;
         if (e1) m_rd[p1] = 1'b1;
         if (hd) begin
            e.dt = q0 ? p0 : (q1 ? p1 : m_fl.pop_front());
            e.dv = m_ver[e.dt];
            m_ver[e.dt] = m_ver[e.dt] + 2'd1;
            m_rd[e.dt] = 1'b0;
            m_map[d] = e.dt;
         end
         sb.push_back(e);
      end
      if (rv) m_fl.push_back(PW'(rt));
      #1;
      chk("R10", "stall", stall, st);
      @(negedge clk);
      in_valid = 1'b0; rel_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      chk("R1", "watchdog expired", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) m_map[i] = PW'(i);
      for (int i = 0; i < NP; i++) begin m_rd[i] = 1'b1; m_ver[i] = '0; end
      for (int i = NL; i < NP; i++) m_fl.push_back(PW'(i));
      repeat (3) @(negedge clk);
      chk("R1", "out_valid at reset", out_valid, 0);
      chk("R1", "stall at reset", stall, 0);
      rst_n = 1'b1;
      @(negedge clk);
      //     lbl    v  hd d  e0 s0 l0 e1 s1 l1 rv rt
      issue("R1",   1, 1, 1, 1, 2, 1, 1, 3, 1, 0, 0);  // arch regs already read -> p16
      issue("R4",   1, 1, 4, 1, 1, 1, 0, 0, 0, 0, 0);  // hint reuses p16
      issue("R12",  1, 1, 5, 1, 4, 0, 0, 0, 0, 0, 0);  // p16 unread again, no hint -> alloc
      issue("R2",   1, 1, 4, 1, 4, 1, 0, 0, 0, 0, 0);  // p16 already read -> alloc
      issue("R3",   1, 1, 5, 1, 5, 0, 0, 0, 0, 0, 0);  // same logical reg reuse
      issue("R6",   1, 1, 7, 1, 0, 0, 0, 0, 0, 0, 0);
      issue("R6",   1, 1, 8, 1, 0, 0, 0, 0, 0, 0, 0);
      issue("R9",   1, 1, 9, 1, 7, 1, 1, 8, 1, 0, 0);  // both qualify -> src0
      for (int k = 0; k < 5; k++)
         issue("R7", 1, 1, 9, 1, 9, 0, 0, 0, 0, 0, 0);  // chain, version wraps
      issue("R6",   1, 1, 10, 1, 0, 0, 0, 0, 0, 0, 0);
      issue("R11",  1, 0, 0, 1, 10, 1, 0, 0, 0, 0, 0);  // no dst, sets flag
      issue("R11",  1, 1, 11, 1, 10, 1, 0, 0, 0, 0, 0); // cannot reuse now
      issue("R4",   1, 1, 12, 1, 11, 0, 1, 11, 0, 0, 0); // no hint -> alloc
      while (m_fl.size() > 0)
         issue("R6", 1, 1, 13, 1, 0, 0, 0, 0, 0, 0, 0);
      issue("R10",  1, 1, 14, 1, 0, 0, 0, 0, 0, 0, 0);  // empty -> stall
      issue("R13",  1, 1, 14, 1, 0, 0, 0, 0, 0, 1, 3);  // stall, release kept
      issue("R13",  1, 1, 14, 1, 0, 0, 0, 0, 0, 0, 0);  // gets p3
      issue("R13",  0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4);
      issue("R13",  1, 1, 15, 1, 0, 0, 0, 0, 0, 1, 5);  // pop p4, push p5
      issue("R13",  1, 1, 15, 1, 0, 0, 0, 0, 0, 0, 0);  // gets p5
      issue("R10",  1, 1, 15, 1, 0, 0, 0, 0, 0, 0, 0);  // empty again
      issue("R3",   1, 1, 15, 1, 15, 0, 0, 0, 0, 0, 0); // reuse allowed while empty
      repeat (3) @(negedge clk);
      chk("R10", "pending results", sb.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule